// File: doc/BRIEF.md
# High-Bandwidth Isochronous PID Sequence Checker

This block watches the data PIDs that arrive on a high-bandwidth isochronous OUT endpoint. Such an endpoint carries one, two or three transactions in each micro-frame. Every received packet is stored in one bank of a small ring of banks. The checker compares the PID of each packet with the sequence USB 2.0 requires for the configured transaction count. When the group of a micro-frame breaks that sequence, every bank that holds a packet of that group carries a bad tag.

Firmware drains the banks in order. The error output stays high for as long as the current (oldest busy) bank carries a bad tag. It clears only once the firmware has released banks until the current one belongs to a later group. The block also reports the PID stored with the current bank. For the IN direction, it reports the PID to place on the next packet sent in the current micro-frame.

Top module: `hbiso_pid_chk`

## Requirements
- R1: After reset, `err_o` and `irq_o` are 0, no bank is busy, and `in_pid_o` shows the first PID of a micro-frame for the configured count.
- R2: PIDs are 2-bit codes: 0 = DATA0, 1 = DATA1, 2 = DATA2, 3 = MDATA. The transaction count n is `mult_i`, and a value of 0 counts as 1. The OUT sequence expected in a micro-frame is DATA0 for n=1; MDATA, DATA1 for n=2; and MDATA, MDATA, DATA2 for n=3.
- R3: When a packet's PID differs from the expected one at its position, every bank of that micro-frame's group is tagged bad. This includes banks written earlier in the same micro-frame and every later packet of that micro-frame.
- R4: A packet received after n packets have already arrived in the same micro-frame makes the whole group bad.
- R5: A micro-frame start that arrives after more than 0 but fewer than n packets in the open micro-frame tags that partial group bad.
- R6: `err_o` is 1 exactly when at least one bank is busy and the current bank carries a bad tag. Releasing banks (`bank_rel_i`) walks through them in write order.
- R7: A group that follows its sequence leaves no tag. A bad group does not tag the banks of other groups.
- R8: `irq_o` equals `err_o` AND `err_en_i`.
- R9: While a bank is busy, `cur_pid_o` is the PID that was received into the current bank.
- R10: `in_pid_o` gives the PID for the next IN packet, chosen from the number of IN packets still left in the micro-frame: 3 left gives DATA2, 2 left gives DATA1, 1 or fewer left gives DATA0. Each `in_sent_i` pulse uses one, and a micro-frame start restores the full count.
- R11: In a cycle that has both a micro-frame start and a packet, the packet opens the new micro-frame. In a cycle that has both a release and a packet, the release acts on the oldest bank and the packet is queued behind it.
- R12: A packet must not arrive while all NBANK banks are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mult_i | input | 2 | Transactions per micro-frame (0 counts as 1) |
| uframe_i | input | 1 | Micro-frame start strobe |
| pkt_vld_i | input | 1 | OUT packet received and stored |
| pkt_pid_i | input | 2 | PID code of the received packet |
| bank_rel_i | input | 1 | Firmware releases the current bank |
| err_en_i | input | 1 | Interrupt enable for the error flag |
| in_sent_i | input | 1 | One IN packet has been sent |
| err_o | output | 1 | Current bank belongs to a bad group |
| irq_o | output | 1 | Endpoint interrupt from the error flag |
| cur_pid_o | output | 2 | PID stored with the current bank |
| in_pid_o | output | 2 | PID for the next IN packet |

## Verification
The bench runs correct groups for n = 1, 2 and 3, which shows that the checker does not raise false errors. It then runs a wrong last PID in a three-packet group, which shows whether the tag reaches the earlier banks and not only the failing one. A packet beyond the count and a micro-frame cut short by an early start are run next. These separate the overflow rule from the partial-group rule. Runs with a start strobe or a release in the same cycle as a packet, and with interleaved good and bad groups, show that tags follow their banks through the release order.

// File: rtl/hbiso_pkg.sv
package hbiso_pkg;
  typedef enum logic [1:0] {PID_D0 = 2'd0, PID_D1 = 2'd1, PID_D2 = 2'd2, PID_MD = 2'd3} pid_e;

  function automatic logic [1:0] grp_len(input logic [1:0] m);
    return (m == 2'd0) ? 2'd1 : m;
  endfunction

  // expected OUT PID at position k of a group of n
  function automatic pid_e out_exp(input logic [1:0] n, input logic [1:0] k);
    case (n)
      2'd2:    return (k == 2'd0) ? PID_MD : PID_D1;
      2'd3:    return (k < 2'd2) ? PID_MD : PID_D2;
      default: return PID_D0;
    endcase
  endfunction

  // next IN PID from packets still left in the micro-frame
  function automatic pid_e in_next(input logic [1:0] n, input logic [1:0] sent);
    logic [1:0] rem;
    rem = (n > sent) ? n - sent : 2'd0;
    case (rem)
      2'd3:    return PID_D2;
      2'd2:    return PID_D1;
      default: return PID_D0;
    endcase
  endfunction
endpackage

// File: rtl/hbiso_seq_chk.sv
module hbiso_seq_chk
  import hbiso_pkg::*;
#(
  parameter int NBANK = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uframe_i,
  input  logic             pkt_vld_i,
  input  logic [1:0]       pkt_pid_i,
  input  logic [1:0]       n_i,
  input  logic [NBANK-1:0] wr_oh_i,
  output logic [NBANK-1:0] tag_set_o
);
  logic [1:0]       cnt_q, cnt_d, cnt_e;
  logic             bad_q, bad_d, bad_e, miss;
  logic [NBANK-1:0] mask_q, mask_d, mask_e;

  always_comb begin
    cnt_e  = uframe_i ? 2'd0 : cnt_q;
    bad_e  = uframe_i ? 1'b0 : bad_q;
    mask_e = uframe_i ? '0 : mask_q;
    tag_set_o = '0;
    // early micro-frame start closes a short group
    if (uframe_i && cnt_q != 2'd0 && cnt_q < n_i) tag_set_o = mask_q;
    miss   = (cnt_e >= n_i) || (pid_e'(pkt_pid_i) != out_exp(n_i, cnt_e));
    cnt_d  = cnt_e;
    bad_d  = bad_e;
    mask_d = mask_e;
    if (pkt_vld_i) begin
      bad_d  = bad_e | miss;
      mask_d = mask_e | wr_oh_i;
      if (cnt_e != 2'd3) cnt_d = cnt_e + 2'd1;
      if (bad_e | miss) tag_set_o = tag_set_o | mask_e | wr_oh_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 2'd0;
      bad_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      bad_q  <= bad_d;
      mask_q <= mask_d;
    end
  end

  // R11
  cnt_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uframe_i |=> cnt_q <= 2'd1);
endmodule

// File: rtl/hbiso_bank_trk.sv
module hbiso_bank_trk #(
  parameter int NBANK = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [1:0]                 pid_i,
  input  logic                       rel_i,
  input  logic [NBANK-1:0]           set_i,
  output logic [NBANK-1:0]           wr_oh_o,
  output logic [$clog2(NBANK+1)-1:0] busy_o,
  output logic                       cur_tag_o,
  output logic [1:0]                 cur_pid_o
);
  localparam int PW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int CW = $clog2(NBANK+1);

  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    busy_q;
  logic [NBANK-1:0] tag_q;
  logic [1:0]       pid_q [NBANK];
  logic             rel_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(NBANK-1)) ? '0 : p + PW'(1);
  endfunction

  assign rel_ok    = rel_i && (busy_q != '0);
  assign wr_oh_o   = NBANK'(1) << wr_ptr_q;
  assign busy_o    = busy_q;
  assign cur_tag_o = (busy_q != '0) && tag_q[rd_ptr_q];
  assign cur_pid_o = pid_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      busy_q   <= '0;
    end else begin
      if (wr_i)   wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rel_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      busy_q <= busy_q + CW'(wr_i) - CW'(rel_ok);
    end
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic clr;
    assign clr = (wr_i && wr_ptr_q == PW'(i)) || (rel_ok && rd_ptr_q == PW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[i] <= 1'b0;
        pid_q[i] <= 2'd0;
      end else begin
        tag_q[i] <= set_i[i] | (tag_q[i] & ~clr);
        if (wr_i && wr_ptr_q == PW'(i)) pid_q[i] <= pid_i;
      end
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> busy_q != CW'(NBANK));
  // R9
  cur_pid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && busy_q == '0 |=> cur_pid_o == $past(pid_i));
endmodule

// File: rtl/hbiso_in_tgl.sv
module hbiso_in_tgl
  import hbiso_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uframe_i,
  input  logic       sent_i,
  input  logic [1:0] n_i,
  output logic [1:0] pid_o
);
  logic [1:0] sent_q, base;

  assign base  = uframe_i ? 2'd0 : sent_q;
  assign pid_o = in_next(n_i, sent_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sent_q <= 2'd0;
    else if (sent_i && base != 2'd3)  sent_q <= base + 2'd1;
    else                              sent_q <= base;
  end

  // R10
  in_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uframe_i && !sent_i && n_i == 2'd3 && $stable(n_i) |=> n_i != 2'd3 || pid_o == 2'd2);
endmodule

// File: rtl/hbiso_pid_chk.sv
module hbiso_pid_chk
  import hbiso_pkg::*;
#(
  parameter int NBANK = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mult_i,
  input  logic       uframe_i,
  input  logic       pkt_vld_i,
  input  logic [1:0] pkt_pid_i,
  input  logic       bank_rel_i,
  input  logic       err_en_i,
  input  logic       in_sent_i,
  output logic       err_o,
  output logic       irq_o,
  output logic [1:0] cur_pid_o,
  output logic [1:0] in_pid_o
);
  localparam int CW = $clog2(NBANK+1);

  logic [1:0]       n;
  logic [NBANK-1:0] wr_oh, tag_set;
  logic [CW-1:0]    busy;

  assign n = grp_len(mult_i);

  hbiso_seq_chk #(.NBANK(NBANK)) i_seq (
    .clk_i, .rst_ni, .uframe_i, .pkt_vld_i, .pkt_pid_i,
    .n_i(n), .wr_oh_i(wr_oh), .tag_set_o(tag_set)
  );

  hbiso_bank_trk #(.NBANK(NBANK)) i_bank (
    .clk_i, .rst_ni, .wr_i(pkt_vld_i), .pid_i(pkt_pid_i), .rel_i(bank_rel_i),
    .set_i(tag_set), .wr_oh_o(wr_oh), .busy_o(busy), .cur_tag_o(err_o),
    .cur_pid_o(cur_pid_o)
  );

  hbiso_in_tgl i_in (
    .clk_i, .rst_ni, .uframe_i, .sent_i(in_sent_i), .n_i(n), .pid_o(in_pid_o)
  );

  assign irq_o = err_o & err_en_i;

  // R3
  first_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_i && uframe_i && n == 2'd1 && pkt_pid_i != 2'd0 && busy == '0 |=> err_o);
  // R6
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_rel_i && busy == CW'(1) && !pkt_vld_i |=> !err_o);
endmodule

// File: tb/test_hbiso_pid_chk.sv
module test_hbiso_pid_chk;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mult = 2'd3, pid = 2'd0;
  logic uf = 0, pv = 0, rel = 0, en = 0, ins = 0;
  logic err, irq;
  logic [1:0] cur_pid, in_pid;

  int n_chk = 0, n_err = 0;
  string scen = "R1";

  // reference model state
  int qpid[$];
  int qg[$];
  bit gbad [0:4095];
  int gid = 0, cnt = 0, ink = 0;

  always #(CLK_P/2) clk = ~clk;

  hbiso_pid_chk i_hbiso_pid_chk (
    .clk_i(clk), .rst_ni(rst_n), .mult_i(mult), .uframe_i(uf), .pkt_vld_i(pv),
    .pkt_pid_i(pid), .bank_rel_i(rel), .err_en_i(en), .in_sent_i(ins),
    .err_o(err), .irq_o(irq), .cur_pid_o(cur_pid), .in_pid_o(in_pid)
  );

  function automatic int nlen(input int m);
    return (m == 0) ? 1 : m;
  endfunction

  function automatic int want(input int n, input int k);
    if (n == 1) return 0;
    if (n == 2) return (k == 0) ? 3 : 1;
    return (k < 2) ? 3 : 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, scen, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n, e, left;
    n = nlen(mult);
    e = (qg.size() > 0) ? int'(gbad[qg[0]]) : 0;
    chk("R6 err_o", int'(err), e);
    chk("R8 irq_o", int'(irq), e & int'(en));
    if (qpid.size() > 0) chk("R9 cur_pid_o", int'(cur_pid), qpid[0]);
    left = n - ink;
    chk("R10 in_pid_o", int'(in_pid), (left >= 3) ? 2 : (left == 2) ? 1 : 0);
  endtask

  task automatic model_step();
    int n;
    n = nlen(mult);
    if (uf) begin
      if (cnt > 0 && cnt < n) gbad[gid] = 1'b1;
      gid++;
      cnt = 0;
      ink = 0;
    end
    if (rel && qg.size() > 0) begin
      void'(qpid.pop_front());
      void'(qg.pop_front());
    end
    if (pv) begin
      if (cnt >= n || int'(pid) != want(n, cnt)) gbad[gid] = 1'b1;
      qpid.push_back(int'(pid));
      qg.push_back(gid);
      cnt++;
    end
    if (ins) ink++;
  endtask

  task automatic cyc(input bit u, input bit p, input int pd, input bit r, input bit s);
    uf = u; pv = p; pid = 2'(pd); rel = r; ins = s;
    @(posedge clk);
    model_step();
    @(negedge clk);
    uf = 0; pv = 0; rel = 0; ins = 0;
    compare();
  endtask

  task automatic drain();
    while (qg.size() > 0) cyc(0, 0, 0, 1, 0);
  endtask

  bit done = 0;
  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    scen = "R1";
    chk("R1 err_o", int'(err), 0);
    chk("R1 irq_o", int'(irq), 0);
    chk("R1 in_pid_o", int'(in_pid), 2);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    en = 1;

    // R2/R7: good groups for each count
    scen = "R7 n=1"; mult = 1;
    cyc(1, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0); drain();
    scen = "R7 n=2"; mult = 2;
    cyc(1, 1, 3, 0, 0); cyc(0, 1, 1, 0, 0); drain();
    scen = "R7 n=3"; mult = 3;
    cyc(1, 1, 3, 0, 0); cyc(0, 1, 3, 0, 0); cyc(0, 1, 2, 0, 0); drain();
    scen = "R2 mult=0"; mult = 0;
    cyc(1, 1, 0, 0, 0); drain();

    // R3: wrong last PID tags the whole group
    scen = "R3 n=3 bad last"; mult = 3;
    cyc(1, 1, 3, 0, 0); cyc(0, 1, 3, 0, 0); cyc(0, 1, 1, 0, 0);
    chk("R3 first bank tagged", int'(err), 1);
    drain();
    scen = "R3 n=1 DATA1"; mult = 1;
    cyc(1, 1, 1, 0, 0); drain();

    // R4: extra packet in micro-frame
    scen = "R4 extra"; mult = 1;
    cyc(1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    chk("R4 group tagged", int'(err), 1);
    drain();

    // R5: early micro-frame start, then a good group
    scen = "R5 partial"; mult = 2;
    cyc(1, 1, 3, 0, 0); cyc(1, 1, 3, 0, 0); cyc(0, 1, 1, 0, 0);
    chk("R5 partial tagged", int'(err), 1);
    cyc(0, 0, 0, 1, 0);
    chk("R7 next group clean", int'(err), 0);
    drain();

    // R8: enable gating
    scen = "R8"; mult = 1;
    en = 0; cyc(1, 1, 2, 0, 0);
    en = 1; cyc(0, 0, 0, 0, 0);
    drain();

    // R11: start strobe with packet, release with packet
    scen = "R11"; mult = 2;
    cyc(1, 1, 3, 0, 0); cyc(0, 1, 1, 0, 0);
    cyc(1, 1, 3, 1, 0); cyc(0, 1, 0, 1, 0);
    chk("R11 bad group reached", int'(err), 1);
    drain();
    cyc(1, 1, 3, 0, 0); cyc(0, 1, 1, 0, 0); cyc(1, 1, 3, 1, 0);
    drain();

    // R10: IN toggle
    scen = "R10"; mult = 3;
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 1); mult = 2; cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1);

    // interleaved good/bad groups keep their tags
    scen = "R6 interleave"; mult = 1;
    for (int i = 0; i < 20; i++) begin
      cyc(1, 1, (i % 3 == 0) ? 3 : 0, (qg.size() >= 2), 0);
    end
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule